// File: doc/BRIEF.md
# BCD Calendar and Alarm Unit

This block keeps a calendar of seconds, minutes, hours, day of week, day of month, month and two-digit year, and advances it by one second per update cycle. A once-per-second strobe starts each cycle. The cycle opens an update-in-progress window of fixed length. At the end of the window the time registers take their new values in the presentation format currently selected, the alarm comparison runs, and one-cycle set strobes for the alarm and update-ended flags come out.

The presentation format is chosen by two mode pins: packed BCD (tens digit in the upper nibble) or plain binary, and 24-hour or 12-hour hours with bit 7 as the PM marker. Inside, the time is kept in binary. Host writes are decoded into that binary time with the format in force at the moment of the write. The byte written is also stored unchanged in the visible register. The three alarm bytes are compared against the freshly formatted seconds, minutes and hours. A byte whose top two bits are both set matches any value.

Host writes have no handshake. A write is a single-cycle strobe and is always accepted in the cycle it is presented. There is no back-pressure. The status and strobe outputs are plain levels and pulses.

Top module: `rtc_calendar_unit`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, day of month 0x01, month 0x01, year 0x00. uip_o, af_set_o, uf_set_o and irq_set_o are low.
- R2: A tick starts an update cycle only when divider_sel equals 3'b010. With any other code the tick is ignored: uip_o stays low and no register changes.
- R3: While mode_set is high a tick is ignored and uip_o stays low. Raising mode_set inside the update window cancels that update: uip_o drops on the next cycle, no strobe follows, and the time is unchanged.
- R4: When a tick is accepted, uip_o is high for exactly UIP_DELAY cycles. In the cycle uip_o falls, the time registers show the advanced time and uf_set_o pulses for one cycle. A tick that arrives inside the window is ignored.
- R5: With mode_bin low every field is packed BCD. With mode_bin high every field is plain binary.
- R6: With mode_24h low the hour reads 1 to 12, with bit 7 set for PM. Hour 0 reads as 12 AM (0x12 in BCD), hour 12 reads as 12 PM (0x92 in BCD), and 11 PM rolls to 12 AM.
- R7: The second carries into the minute and the minute into the hour. Passing midnight advances the day of week, which wraps from 7 to 1. A month rolls from 12 to 1, and the year from 99 to 0. April, June, September and November have 30 days.
- R8: The year value is read as 2000 plus the year. February has 29 days when the year is a multiple of 4, year 00 included, and 28 days otherwise.
- R9: After each update af_set_o pulses together with uf_set_o when all three alarm bytes match the new seconds, minutes and hours. Each alarm byte is compared with the register byte in its current format, and an alarm byte with bits [7:6] = 2'b11 matches any value.
- R10: irq_set_o pulses with uf_set_o when update_ie is high, or when the alarm matched and alarm_ie is high. Otherwise it stays low.
- R11: A host write presented in the cycle that would end the update window takes that cycle. The update is deferred by one cycle and advances the value just written.
- R12: Changing mode_bin or mode_24h does not convert the stored register bytes. Only the next update writes the time in the new format.
- R13: wr_sel selects the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm, 9 hours alarm. A time write shows its raw byte in the register on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe that starts an update cycle |
| divider_sel | input | 3 | Oscillator/divider code; 3'b010 lets time run |
| mode_set | input | 1 | Set mode: updates suppressed |
| mode_bin | input | 1 | 1 = binary fields, 0 = packed BCD |
| mode_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| alarm_ie | input | 1 | Alarm interrupt enable |
| update_ie | input | 1 | Update-ended interrupt enable |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 4 | Field selected by the write |
| wr_data | input | 8 | Byte written |
| sec_o | output | 8 | Seconds register |
| min_o | output | 8 | Minutes register |
| hour_o | output | 8 | Hours register |
| wday_o | output | 8 | Day-of-week register |
| mday_o | output | 8 | Day-of-month register |
| month_o | output | 8 | Month register |
| year_o | output | 8 | Year register |
| uip_o | output | 1 | Update in progress |
| af_set_o | output | 1 | One-cycle alarm flag set strobe |
| uf_set_o | output | 1 | One-cycle update-ended flag set strobe |
| irq_set_o | output | 1 | One-cycle interrupt flag set strobe |

## Verification
Two functions can claim the time registers in the same cycle: a host write and the commit that closes the update window. The bench fires a tick, counts cycles to the last cycle of the window, and presents a seconds write exactly there. It then expects the written byte one cycle later with uip_o still high and no strobe. One cycle after that it expects uf_set_o with the written value advanced by one. A second overlap, set mode raised in the middle of the window, is judged by uip_o dropping, no uf_set_o arriving, and the seconds staying put.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BYTE_W = 8;
  localparam int SEL_W  = 4;
  localparam int DIV_W  = 3;
  localparam logic [DIV_W-1:0] RUN_CODE = 3'b010;

  typedef logic [BYTE_W-1:0] byte_t;

  // field select codes (host write decode)
  localparam logic [SEL_W-1:0] SEL_SEC   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_MIN   = 4'd1;
  localparam logic [SEL_W-1:0] SEL_HOUR  = 4'd2;
  localparam logic [SEL_W-1:0] SEL_WDAY  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_MDAY  = 4'd4;
  localparam logic [SEL_W-1:0] SEL_MON   = 4'd5;
  localparam logic [SEL_W-1:0] SEL_YEAR  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_ASEC  = 4'd7;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hour;
    byte_t wday;
    byte_t mday;
    byte_t mon;
    byte_t year;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 8'd0, min: 8'd0, hour: 8'd0,
                                 wday: 8'd1, mday: 8'd1, mon: 8'd1,
                                 year: 8'd0};

  // register byte -> binary value
  function automatic byte_t from_fmt(byte_t b, logic bin);
    byte_t tens;
    byte_t ones;
    tens = {4'd0, b[7:4]};
    ones = {4'd0, b[3:0]};
    return bin ? b : byte_t'(tens * 8'd10 + ones);
  endfunction

  // binary value -> register byte
  function automatic byte_t to_fmt(byte_t v, logic bin);
    byte_t t;
    byte_t o;
    t = v / 8'd10;
    o = v % 8'd10;
    return bin ? v : {t[3:0], o[3:0]};
  endfunction

  function automatic byte_t hour_from_fmt(byte_t b, logic bin, logic h24);
    byte_t h;
    h = from_fmt({1'b0, b[6:0]}, bin);
    if (!h24) begin
      if (h == 8'd12) h = 8'd0;
      if (b[7])       h = h + 8'd12;
    end
    return h;
  endfunction

  function automatic byte_t hour_to_fmt(byte_t h, logic bin, logic h24);
    byte_t h12;
    byte_t r;
    if (h24) begin
      r = to_fmt(h, bin);
    end else begin
      h12 = h % 8'd12;
      if (h12 == 8'd0) h12 = 8'd12;
      r = to_fmt(h12, bin);
      if (h >= 8'd12) r[7] = 1'b1;
    end
    return r;
  endfunction

  // year taken as 2000 + value: multiple of 4 is the whole leap rule
  function automatic byte_t month_days(byte_t mon, byte_t year);
    byte_t d;
    case (mon)
      8'd2:                     d = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  d = 8'd30;
      default:                  d = 8'd31;
    endcase
    return d;
  endfunction

  function automatic cal_t next_second(cal_t c);
    cal_t n;
    n = c;
    if (c.sec >= 8'd59) begin
      n.sec = 8'd0;
      if (c.min >= 8'd59) begin
        n.min = 8'd0;
        if (c.hour >= 8'd23) begin
          n.hour = 8'd0;
          n.wday = (c.wday >= 8'd7) ? 8'd1 : c.wday + 8'd1;
          if (c.mday >= month_days(c.mon, c.year)) begin
            n.mday = 8'd1;
            if (c.mon >= 8'd12) begin
              n.mon  = 8'd1;
              n.year = (c.year >= 8'd99) ? 8'd0 : c.year + 8'd1;
            end else begin
              n.mon = c.mon + 8'd1;
            end
          end else begin
            n.mday = c.mday + 8'd1;
          end
        end else begin
          n.hour = c.hour + 8'd1;
        end
      end else begin
        n.min = c.min + 8'd1;
      end
    end else begin
      n.sec = c.sec + 8'd1;
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
// Binary shadow of the calendar; host writes are decoded with the live format.
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  byte_t            wr_data,
  input  logic             mode_bin,
  input  logic             mode_24h,
  input  logic             commit,
  output cal_t             nxt_o
);

  cal_t cur_q;

  always_comb nxt_o = next_second(cur_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= CAL_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  cur_q.sec  <= from_fmt(wr_data, mode_bin);
        SEL_MIN:  cur_q.min  <= from_fmt(wr_data, mode_bin);
        SEL_HOUR: cur_q.hour <= hour_from_fmt(wr_data, mode_bin, mode_24h);
        SEL_WDAY: cur_q.wday <= from_fmt(wr_data, mode_bin);
        SEL_MDAY: cur_q.mday <= from_fmt(wr_data, mode_bin);
        SEL_MON:  cur_q.mon  <= from_fmt(wr_data, mode_bin);
        SEL_YEAR: cur_q.year <= from_fmt(wr_data, mode_bin);
        default:  ;
      endcase
    end else if (commit) begin
      cur_q <= nxt_o;
    end
  end

endmodule

// File: rtl/rtc_display_regs.sv
// Visible register bytes: raw host bytes, or the formatted next time on commit.
module rtc_display_regs
  import rtc_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  byte_t            wr_data,
  input  logic             mode_bin,
  input  logic             mode_24h,
  input  logic             commit,
  input  cal_t             nxt_i,
  output cal_t             fmt_o,
  output cal_t             disp_o
);

  always_comb begin
    fmt_o.sec  = to_fmt(nxt_i.sec,  mode_bin);
    fmt_o.min  = to_fmt(nxt_i.min,  mode_bin);
    fmt_o.hour = hour_to_fmt(nxt_i.hour, mode_bin, mode_24h);
    fmt_o.wday = to_fmt(nxt_i.wday, mode_bin);
    fmt_o.mday = to_fmt(nxt_i.mday, mode_bin);
    fmt_o.mon  = to_fmt(nxt_i.mon,  mode_bin);
    fmt_o.year = to_fmt(nxt_i.year, mode_bin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_o <= CAL_RESET;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SEC:  disp_o.sec  <= wr_data;
        SEL_MIN:  disp_o.min  <= wr_data;
        SEL_HOUR: disp_o.hour <= wr_data;
        SEL_WDAY: disp_o.wday <= wr_data;
        SEL_MDAY: disp_o.mday <= wr_data;
        SEL_MON:  disp_o.mon  <= wr_data;
        SEL_YEAR: disp_o.year <= wr_data;
        default:  ;
      endcase
    end else if (commit) begin
      disp_o <= fmt_o;
    end
  end

endmodule

// File: rtl/rtc_alarm_match.sv
// Alarm bytes and their comparison against the formatted next time.
module rtc_alarm_match
  import rtc_cal_pkg::*;
#(
  parameter int ALARM_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  byte_t            wr_data,
  input  byte_t            sec_i,
  input  byte_t            min_i,
  input  byte_t            hour_i,
  output logic             match_o
);

  byte_t             field [ALARM_N];
  byte_t             alarm_q [ALARM_N];
  logic [ALARM_N-1:0] hit;

  assign field[0] = sec_i;
  assign field[1] = min_i;
  assign field[2] = hour_i;

  for (genvar i = 0; i < ALARM_N; i++) begin : g_alarm
    localparam logic [SEL_W-1:0] MY_SEL = SEL_ASEC + SEL_W'(i);

    always_ff @(posedge clk) begin
      if (!rst_n)                        alarm_q[i] <= '0;
      else if (wr_en && wr_sel == MY_SEL) alarm_q[i] <= wr_data;
    end

    assign hit[i] = (alarm_q[i][7:6] == 2'b11) || (alarm_q[i] == field[i]);
  end

  assign match_o = &hit;

endmodule

// File: rtl/rtc_update_seq.sv
// Update cycle sequencer: gating, in-progress window, commit and flag strobes.
module rtc_update_seq
  import rtc_cal_pkg::*;
#(
  parameter int UIP_DELAY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] divider_sel,
  input  logic             mode_set,
  input  logic             wr_en,
  input  logic             alarm_match,
  input  logic             alarm_ie,
  input  logic             update_ie,
  output logic             uip_o,
  output logic             commit_o,
  output logic             af_set_o,
  output logic             uf_set_o,
  output logic             irq_set_o
);

  localparam int CNT_W = (UIP_DELAY > 1) ? $clog2(UIP_DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(UIP_DELAY - 1);

  typedef enum logic {S_IDLE, S_WAIT} seq_e;

  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q;

  assign uip_o    = (state_q == S_WAIT);
  // a host write owns the registers this cycle; the commit slips by one
  assign commit_o = uip_o && !mode_set && (cnt_q == LAST) && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      af_set_o  <= 1'b0;
      uf_set_o  <= 1'b0;
      irq_set_o <= 1'b0;
    end else begin
      af_set_o  <= commit_o && alarm_match;
      uf_set_o  <= commit_o;
      irq_set_o <= commit_o && ((alarm_match && alarm_ie) || update_ie);
      case (state_q)
        S_IDLE: begin
          if (tick && !mode_set && divider_sel == RUN_CODE) begin
            state_q <= S_WAIT;
            cnt_q   <= '0;
          end
        end
        S_WAIT: begin
          if (mode_set) begin
            state_q <= S_IDLE;
          end else if (cnt_q == LAST) begin
            if (!wr_en) state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rtc_calendar_unit.sv
module rtc_calendar_unit
  import rtc_cal_pkg::*;
#(
  parameter int UIP_DELAY = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1hz,
  input  logic [2:0]  divider_sel,
  input  logic        mode_set,
  input  logic        mode_bin,
  input  logic        mode_24h,
  input  logic        alarm_ie,
  input  logic        update_ie,
  input  logic        wr_en,
  input  logic [3:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  wday_o,
  output logic [7:0]  mday_o,
  output logic [7:0]  month_o,
  output logic [7:0]  year_o,
  output logic        uip_o,
  output logic        af_set_o,
  output logic        uf_set_o,
  output logic        irq_set_o
);

  cal_t nxt_bin;
  cal_t nxt_fmt;
  cal_t disp;
  logic commit;
  logic alarm_match;

  rtc_update_seq #(.UIP_DELAY(UIP_DELAY)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick_1hz),
    .divider_sel (divider_sel),
    .mode_set    (mode_set),
    .wr_en       (wr_en),
    .alarm_match (alarm_match),
    .alarm_ie    (alarm_ie),
    .update_ie   (update_ie),
    .uip_o       (uip_o),
    .commit_o    (commit),
    .af_set_o    (af_set_o),
    .uf_set_o    (uf_set_o),
    .irq_set_o   (irq_set_o)
  );

  rtc_time_core i_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .mode_bin (mode_bin),
    .mode_24h (mode_24h),
    .commit   (commit),
    .nxt_o    (nxt_bin)
  );

  rtc_display_regs i_disp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .mode_bin (mode_bin),
    .mode_24h (mode_24h),
    .commit   (commit),
    .nxt_i    (nxt_bin),
    .fmt_o    (nxt_fmt),
    .disp_o   (disp)
  );

  rtc_alarm_match #(.ALARM_N(3)) i_alarm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .sec_i   (nxt_fmt.sec),
    .min_i   (nxt_fmt.min),
    .hour_i  (nxt_fmt.hour),
    .match_o (alarm_match)
  );

  assign sec_o   = disp.sec;
  assign min_o   = disp.min;
  assign hour_o  = disp.hour;
  assign wday_o  = disp.wday;
  assign mday_o  = disp.mday;
  assign month_o = disp.mon;
  assign year_o  = disp.year;

endmodule

// File: rtl/rtc_calendar_unit_chk.sv
module rtc_calendar_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] divider_sel,
  input logic       mode_set,
  input logic       wr_en,
  input logic [7:0] sec_o,
  input logic       uip_o,
  input logic       af_set_o,
  input logic       uf_set_o,
  input logic       irq_set_o
);

  AST_RUN_CODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip_o) |-> ($past(divider_sel) == 3'b010 && !$past(mode_set))); // R2

  AST_SET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> (!uip_o && !uf_set_o)); // R3

  AST_UF_CLOSES_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    uf_set_o |-> (!uip_o && $past(uip_o))); // R4

  AST_TIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!uf_set_o && !$past(wr_en)) |-> $stable(sec_o)); // R4

  AST_AF_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n)
    af_set_o |-> uf_set_o); // R9

  AST_IRQ_WITH_UF: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_o |-> uf_set_o); // R10

endmodule

bind rtc_calendar_unit rtc_calendar_unit_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .divider_sel (divider_sel),
  .mode_set    (mode_set),
  .wr_en       (wr_en),
  .sec_o       (sec_o),
  .uip_o       (uip_o),
  .af_set_o    (af_set_o),
  .uf_set_o    (uf_set_o),
  .irq_set_o   (irq_set_o)
);

// File: tb/test_rtc_calendar_unit.sv
module test_rtc_calendar_unit;

  localparam int CLK_PERIOD = 10;
  localparam int UIP_DELAY  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic [2:0] divider_sel = 3'b010;
  logic       mode_set = 1'b0;
  logic       mode_bin = 1'b0;
  logic       mode_24h = 1'b1;
  logic       alarm_ie = 1'b0;
  logic       update_ie = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;
  logic       uip_o, af_set_o, uf_set_o, irq_set_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_unit #(.UIP_DELAY(UIP_DELAY)) i_rtc_calendar_unit (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .divider_sel(divider_sel),
    .mode_set(mode_set), .mode_bin(mode_bin), .mode_24h(mode_24h),
    .alarm_ie(alarm_ie), .update_ie(update_ie), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o),
    .year_o(year_o), .uip_o(uip_o), .af_set_o(af_set_o),
    .uf_set_o(uf_set_o), .irq_set_o(irq_set_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] wd,
                          input logic [7:0] md, input logic [7:0] mo,
                          input logic [7:0] yr);
    wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, wd);
    wr(4'd4, md); wr(4'd5, mo); wr(4'd6, yr);
  endtask

  // pulse a tick and stop at the negedge where uf_set_o is seen
  task automatic do_update(output int n, output logic uip_first);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    n = 1;
    uip_first = uip_o;
    while (!uf_set_o && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_date(input string req, input logic [7:0] s,
                             input logic [7:0] m, input logic [7:0] h,
                             input logic [7:0] wd, input logic [7:0] md,
                             input logic [7:0] mo, input logic [7:0] yr);
    chk(req, "sec", sec_o, s);     chk(req, "min", min_o, m);
    chk(req, "hour", hour_o, h);   chk(req, "wday", wday_o, wd);
    chk(req, "mday", mday_o, md);  chk(req, "month", month_o, mo);
    chk(req, "year", year_o, yr);
  endtask

  task automatic t_reset();
    expect_date("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    chk("R1", "uip", {7'd0, uip_o}, 8'd0);
    chk("R1", "strobes", {5'd0, af_set_o, uf_set_o, irq_set_o}, 8'd0);
  endtask

  task automatic t_rollover();
    int n; logic u;
    mode_bin = 1'b0; mode_24h = 1'b1;
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    chk("R13", "raw write shown", year_o, 8'h99);
    do_update(n, u);
    chk("R4", "uip after tick", {7'd0, u}, 8'd1);
    chk("R4", "cycles to uf", 8'(n), 8'(UIP_DELAY + 1));
    chk("R4", "uip low at uf", {7'd0, uip_o}, 8'd0);
    expect_date("R7", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    set_time(8'h59, 8'h14, 8'h09, 8'h03, 8'h30, 8'h04, 8'h10);
    do_update(n, u);
    expect_date("R7", 8'h00, 8'h15, 8'h09, 8'h03, 8'h30, 8'h04, 8'h10);
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10);
    do_update(n, u);
    expect_date("R7", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h10);
  endtask

  task automatic t_leap();
    int n; logic u;
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    do_update(n, u);
    chk("R8", "leap 24 mday", mday_o, 8'h29);
    chk("R8", "leap 24 month", month_o, 8'h02);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    do_update(n, u);
    chk("R8", "common 23 mday", mday_o, 8'h01);
    chk("R8", "common 23 month", month_o, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    do_update(n, u);
    chk("R8", "year 00 mday", mday_o, 8'h29);
  endtask

  task automatic t_binary();
    int n; logic u;
    mode_bin = 1'b1; mode_24h = 1'b1;
    set_time(8'h3B, 8'h3B, 8'h17, 8'h05, 8'h1C, 8'h02, 8'h18);
    do_update(n, u);
    expect_date("R5", 8'h00, 8'h00, 8'h00, 8'h06, 8'h1D, 8'h02, 8'h18);
    mode_bin = 1'b0;
  endtask

  task automatic t_12h();
    int n; logic u;
    mode_bin = 1'b0; mode_24h = 1'b0;
    set_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h06, 8'h20);
    do_update(n, u);
    chk("R6", "11PM to 12AM", hour_o, 8'h12);
    chk("R6", "midnight mday", mday_o, 8'h11);
    chk("R6", "midnight wday", wday_o, 8'h03);
    wr(4'd2, 8'h11); wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    do_update(n, u);
    chk("R6", "11AM to 12PM", hour_o, 8'h92);
    wr(4'd1, 8'h59); wr(4'd0, 8'h59);
    do_update(n, u);
    chk("R6", "12PM to 1PM", hour_o, 8'h81);
    mode_24h = 1'b1;
  endtask

  task automatic t_divider();
    logic seen = 1'b0;
    wr(4'd0, 8'h20);
    divider_sel = 3'b110;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    for (int i = 0; i < UIP_DELAY + 4; i++) begin
      if (uip_o || uf_set_o) seen = 1'b1;
      @(negedge clk);
    end
    chk("R2", "no update off-code", {7'd0, seen}, 8'd0);
    chk("R2", "sec held", sec_o, 8'h20);
    divider_sel = 3'b010;
  endtask

  task automatic t_set();
    logic seen = 1'b0;
    wr(4'd0, 8'h40);
    mode_set = 1'b1;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    for (int i = 0; i < UIP_DELAY + 4; i++) begin
      if (uip_o || uf_set_o) seen = 1'b1;
      @(negedge clk);
    end
    chk("R3", "set blocks update", {7'd0, seen}, 8'd0);
    mode_set = 1'b0;
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3", "uip open before abort", {7'd0, uip_o}, 8'd1);
    mode_set = 1'b1;
    @(negedge clk);
    chk("R3", "uip dropped on set", {7'd0, uip_o}, 8'd0);
    mode_set = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < UIP_DELAY + 4; i++) begin
      if (uip_o || uf_set_o) seen = 1'b1;
      @(negedge clk);
    end
    chk("R3", "aborted update silent", {7'd0, seen}, 8'd0);
    chk("R3", "sec unchanged", sec_o, 8'h40);
  endtask

  task automatic t_busy_tick();
    int n = 1;
    logic seen = 1'b0;
    wr(4'd0, 8'h40);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    while (!uf_set_o && n < 40) begin
      @(negedge clk);
      n++;
      tick_1hz = (n == 3);
    end
    tick_1hz = 1'b0;
    chk("R4", "window length with extra tick", 8'(n), 8'(UIP_DELAY + 1));
    chk("R4", "single advance", sec_o, 8'h41);
    @(negedge clk);
    for (int i = 0; i < UIP_DELAY + 4; i++) begin
      if (uip_o || uf_set_o) seen = 1'b1;
      @(negedge clk);
    end
    chk("R4", "extra tick ignored", {7'd0, seen}, 8'd0);
    chk("R4", "sec after idle", sec_o, 8'h41);
  endtask

  task automatic t_alarm();
    int n; logic u;
    mode_bin = 1'b0; mode_24h = 1'b1;
    set_time(8'h04, 8'h20, 8'h10, 8'h02, 8'h05, 8'h03, 8'h21);
    wr(4'd7, 8'h05); wr(4'd8, 8'hC0); wr(4'd9, 8'hFF);
    alarm_ie = 1'b1; update_ie = 1'b0;
    do_update(n, u);
    chk("R9", "match with dont-care", {7'd0, af_set_o}, 8'd1);
    chk("R10", "irq by alarm_ie", {7'd0, irq_set_o}, 8'd1);
    wr(4'd7, 8'h06); wr(4'd8, 8'h21);
    do_update(n, u);
    chk("R9", "minute mismatch", {7'd0, af_set_o}, 8'd0);
    chk("R9", "uf still set", {7'd0, uf_set_o}, 8'd1);
    chk("R10", "no irq on mismatch", {7'd0, irq_set_o}, 8'd0);
    alarm_ie = 1'b0; update_ie = 1'b1;
    wr(4'd8, 8'hC0); wr(4'd7, 8'h07);
    do_update(n, u);
    chk("R9", "match again", {7'd0, af_set_o}, 8'd1);
    chk("R10", "irq by update_ie", {7'd0, irq_set_o}, 8'd1);
    update_ie = 1'b0;
    wr(4'd7, 8'h08);
    do_update(n, u);
    chk("R9", "match no enables", {7'd0, af_set_o}, 8'd1);
    chk("R10", "no irq without enables", {7'd0, irq_set_o}, 8'd0);
  endtask

  task automatic t_collide();
    wr(4'd0, 8'h10);
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    for (int k = 1; k < UIP_DELAY; k++) @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h30;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R11", "write wins commit cycle", sec_o, 8'h30);
    chk("R11", "uip held", {7'd0, uip_o}, 8'd1);
    chk("R11", "no uf yet", {7'd0, uf_set_o}, 8'd0);
    @(negedge clk);
    chk("R11", "deferred uf", {7'd0, uf_set_o}, 8'd1);
    chk("R11", "written value advanced", sec_o, 8'h31);
  endtask

  task automatic t_format();
    int n; logic u;
    mode_bin = 1'b0; mode_24h = 1'b1;
    wr(4'd0, 8'h25); wr(4'd1, 8'h10); wr(4'd2, 8'h15);
    mode_bin = 1'b1; mode_24h = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12", "sec not converted", sec_o, 8'h25);
    chk("R12", "hour not converted", hour_o, 8'h15);
    do_update(n, u);
    chk("R12", "sec in binary", sec_o, 8'h1A);
    chk("R12", "hour 12h binary", hour_o, 8'h83);
    mode_bin = 1'b0; mode_24h = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rollover();
    t_leap();
    t_binary();
    t_12h();
    t_divider();
    t_set();
    t_busy_tick();
    t_alarm();
    t_collide();
    t_format();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule